// File: doc/BRIEF.md
# Idle-Bus Early Write-Back Scheduler

This block sits next to a shared second-level cache and cleans dirty lines before the replacement logic evicts them. It steps a scan pointer through the cache lines, one line per cycle, and looks up each line's dirty state through a scan port. The pointer only moves while the off-chip bus is idle and no demand miss is waiting. A line whose dirty bit is set and which has gone unaccessed for a programmable number of cycles is predicted dead. Such a line becomes the write-back candidate.

The candidate is turned into a write-back request only if the bus is still free and no demand request is pending. A demand access to the candidate before the request starts drops it. Only one request is outstanding at a time, and it is held steady until memory acknowledges it. After the acknowledge, the block tells the cache to clear that line's dirty bit. It does not do so if the line was written while the copy was in flight, because memory would then hold stale data. The data array, the memory controller and the replacement policy are outside this block.

Top module: `ewb_sched`

## Requirements
- R1: In reset, and on the first cycle after it, `wb_req` and `clr_valid` are 0 and `scan_idx` is 0.
- R2: A line is chosen only if the scan port reports it dirty (`scan_dirty`=1) and it has had no access on `acc_*` for at least `dead_thr` cycles. Among the eligible lines, the first one the pointer reaches is chosen. After reset the pointer starts at line 0 and counts upward.
- R3: While `bus_idle` is 0 or `dem_pend` is 1, `scan_idx` does not change and no new `wb_req` begins.
- R4: While no candidate or request is open, `bus_idle`=1 and `dem_pend`=0, `scan_idx` advances by one each cycle and wraps from NLINES-1 to 0.
- R5: Once `wb_req` rises, it stays at 1 and `wb_idx` stays unchanged until the cycle in which `wb_ack` is 1. While it is outstanding, `scan_idx` does not move and no second request starts.
- R6: An acknowledge makes `clr_valid` pulse for exactly one cycle, one cycle later, with `clr_idx` equal to the acknowledged `wb_idx`. `wb_req` falls at the same time.
- R7: A write notification (`acc_valid`=1, `acc_write`=1) for `wb_idx`, arriving while the request is outstanding, suppresses that pulse. The line stays dirty.
- R8: An access to the candidate line after it is picked and before its request starts drops the candidate. No request is issued for that line until it again meets R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dead_thr | input | CW | Cycles without access after which a line counts as dead |
| acc_valid | input | 1 | A cache access to line `acc_idx` happens this cycle |
| acc_idx | input | IW | Line index of the access |
| acc_write | input | 1 | The access is a write |
| bus_idle | input | 1 | Off-chip bus is free this cycle |
| dem_pend | input | 1 | A demand miss is waiting for the bus |
| scan_idx | output | IW | Line whose state is looked up this cycle |
| scan_dirty | input | 1 | Dirty bit of line `scan_idx`, same cycle |
| wb_req | output | 1 | Early write-back request |
| wb_idx | output | IW | Line to write back |
| wb_ack | input | 1 | Memory accepted and completed the write-back |
| clr_valid | output | 1 | One-cycle command to clear a dirty bit |
| clr_idx | output | IW | Line whose dirty bit is cleared |

## Verification
A table of dirty-line and recently-touched-line masks is applied from a fresh reset. Each entry tells apart the three possible outcomes: a write-back of the first eligible line, a line skipped because it is clean, and a line skipped because it is still live. An entry with no eligible line confirms that nothing is issued. Directed runs then check the remaining behaviour:
- the pointer freezes under a busy bus and under a pending demand, which separates the two blocking conditions from the scan itself;
- a held request with a write arriving mid-flight checks the suppressed clear;
- an access that lands exactly during the candidate cycle checks the drop.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_CAND  = 2'd1,
    ST_ISSUE = 2'd2
  } ewb_state_t;
endpackage

// File: rtl/ewb_idle_track.sv
// Per-line idle age. An access clears the age; otherwise it saturates upward.
module ewb_idle_track #(
  parameter int NLINES = 16,
  parameter int CW     = 8,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [IW-1:0]     acc_idx,
  input  logic [CW-1:0]     dead_thr,
  output logic [NLINES-1:0] dead
);
  localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [CW-1:0] age;
    logic          touch;
    assign touch = acc_valid && (acc_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst)                  age <= '0;
      else if (touch)           age <= '0;
      else if (age != AGE_MAX)  age <= age + 1'b1;
    end
    assign dead[g] = (age >= dead_thr);
  end
endmodule

// File: rtl/ewb_scan_ptr.sv
// Round-robin scan pointer over the cache lines.
module ewb_scan_ptr #(
  parameter int NLINES = 16,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(NLINES - 1);

  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (step) begin
      if (ptr == LAST)  ptr <= '0;
      else              ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ewb_issue_fsm.sv
// Picks a candidate, waits for a free bus, holds the request, emits the clear.
module ewb_issue_fsm
  import ewb_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_idle,
  input  logic          dem_pend,
  input  logic [IW-1:0] scan_idx,
  input  logic          scan_dirty,
  input  logic          scan_dead,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  input  logic          acc_write,
  input  logic          wb_ack,
  output logic          step,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  output logic          clr_valid,
  output logic [IW-1:0] clr_idx
);
  ewb_state_t    st;
  logic [IW-1:0] cand;
  logic          rewritten;
  logic          bus_free;
  logic          found;
  logic          cand_hit;
  logic          wr_hit;

  assign bus_free = bus_idle && !dem_pend;
  assign step     = (st == ST_SCAN) && bus_free;
  assign found    = step && scan_dirty && scan_dead &&
                    !(acc_valid && acc_idx == scan_idx);
  assign cand_hit = acc_valid && (acc_idx == cand);
  assign wr_hit   = acc_valid && acc_write && (acc_idx == wb_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_SCAN;
      cand      <= '0;
      rewritten <= 1'b0;
      wb_req    <= 1'b0;
      wb_idx    <= '0;
      clr_valid <= 1'b0;
      clr_idx   <= '0;
    end else begin
      clr_valid <= 1'b0;
      unique case (st)
        ST_SCAN: begin
          if (found) begin
            cand <= scan_idx;
            st   <= ST_CAND;
          end
        end
        ST_CAND: begin
          if (cand_hit) begin
            st <= ST_SCAN;
          end else if (bus_free) begin
            wb_req    <= 1'b1;
            wb_idx    <= cand;
            rewritten <= 1'b0;
            st        <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (wb_ack) begin
            wb_req    <= 1'b0;
            clr_valid <= !(rewritten || wr_hit);
            clr_idx   <= wb_idx;
            st        <= ST_SCAN;
          end else if (wr_hit) begin
            rewritten <= 1'b1;
          end
        end
        default: st <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/ewb_sched.sv
module ewb_sched #(
  parameter int NLINES = 16,
  parameter int CW     = 8,
  localparam int IW    = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] dead_thr,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  input  logic          acc_write,
  input  logic          bus_idle,
  input  logic          dem_pend,
  output logic [IW-1:0] scan_idx,
  input  logic          scan_dirty,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  input  logic          wb_ack,
  output logic          clr_valid,
  output logic [IW-1:0] clr_idx
);
  logic [NLINES-1:0] dead;
  logic              step;

  ewb_idle_track #(.NLINES(NLINES), .CW(CW)) u_track (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .dead_thr(dead_thr), .dead(dead)
  );

  ewb_scan_ptr #(.NLINES(NLINES)) u_ptr (
    .clk(clk), .rst(rst), .step(step), .ptr(scan_idx)
  );

  ewb_issue_fsm #(.NLINES(NLINES)) u_fsm (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .dem_pend(dem_pend),
    .scan_idx(scan_idx), .scan_dirty(scan_dirty), .scan_dead(dead[scan_idx]),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
    .wb_ack(wb_ack), .step(step), .wb_req(wb_req), .wb_idx(wb_idx),
    .clr_valid(clr_valid), .clr_idx(clr_idx)
  );
endmodule

// File: rtl/ewb_sched_chk.sv
module ewb_sched_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [IW-1:0] acc_idx,
  input logic          acc_write,
  input logic          bus_idle,
  input logic          dem_pend,
  input logic [IW-1:0] scan_idx,
  input logic          wb_req,
  input logic [IW-1:0] wb_idx,
  input logic          wb_ack,
  input logic          clr_valid,
  input logic [IW-1:0] clr_idx
);
  p_start_free_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> $past(bus_idle && !dem_pend));

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_idle |=> $stable(scan_idx));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  p_scan_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> $stable(scan_idx));

  p_clr_source_r6: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> ($past(wb_req && wb_ack) && clr_idx == $past(wb_idx)));

  p_clr_single_r6: assert property (@(posedge clk) disable iff (rst)
    clr_valid |=> !clr_valid);

  p_rewrite_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_ack && acc_valid && acc_write && acc_idx == wb_idx)
      |=> !clr_valid);
endmodule

bind ewb_sched ewb_sched_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
  .acc_write(acc_write), .bus_idle(bus_idle), .dem_pend(dem_pend),
  .scan_idx(scan_idx), .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
  .clr_valid(clr_valid), .clr_idx(clr_idx)
);

// File: tb/sim_ewb_sched.sv
module sim_ewb_sched;
  localparam int NLINES = 16;
  localparam int CW     = 8;
  localparam int IW     = 4;
  localparam int THR    = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] dead_thr = CW'(THR);
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic          acc_write = 1'b0;
  logic          bus_idle = 1'b0;
  logic          dem_pend = 1'b0;
  logic [IW-1:0] scan_idx;
  logic          scan_dirty;
  logic          wb_req;
  logic [IW-1:0] wb_idx;
  logic          wb_ack = 1'b0;
  logic          clr_valid;
  logic [IW-1:0] clr_idx;
  logic [NLINES-1:0] dirty_m = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign scan_dirty = dirty_m[scan_idx];

  ewb_sched #(.NLINES(NLINES), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .dead_thr(dead_thr), .acc_valid(acc_valid),
    .acc_idx(acc_idx), .acc_write(acc_write), .bus_idle(bus_idle),
    .dem_pend(dem_pend), .scan_idx(scan_idx), .scan_dirty(scan_dirty),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
    .clr_valid(clr_valid), .clr_idx(clr_idx)
  );

  // {dirty mask, recently touched mask}
  localparam logic [31:0] VEC [6] = '{
    {16'h0020, 16'h0000},
    {16'h0024, 16'h0004},
    {16'h8000, 16'h0000},
    {16'h0003, 16'h0001},
    {16'h0110, 16'h0110},
    {16'hF000, 16'h3000}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_idle = 1'b0; dem_pend = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; wb_ack = 1'b0;
    cyc(3);
    rst = 1'b0;
  endtask

  // wait up to n cycles for wb_req; returns index or -1
  task automatic wait_req(input int n, output int idx);
    idx = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wb_req) begin idx = int'(wb_idx); break; end
    end
  endtask

  initial begin
    int got;
    int exp;
    // R1: reset values
    do_reset();
    check("R1 wb_req", int'(wb_req), 0);
    check("R1 clr_valid", int'(clr_valid), 0);
    check("R1 scan_idx", int'(scan_idx), 0);

    // R2 / R6: table walk
    foreach (VEC[v]) begin
      logic [15:0] dm;
      logic [15:0] rm;
      dm = VEC[v][31:16];
      rm = VEC[v][15:0];
      do_reset();
      dirty_m = dm;
      cyc(THR + 5);
      for (int i = 0; i < NLINES; i++) begin
        if (rm[i]) begin
          acc_valid = 1'b1; acc_idx = IW'(i); acc_write = 1'b0;
          cyc(1);
        end
      end
      acc_valid = 1'b0;
      exp = -1;
      for (int i = NLINES - 1; i >= 0; i--)
        if (dm[i] && !rm[i]) exp = i;
      bus_idle = 1'b1;
      wait_req(24, got);
      check("R2 chosen line", got, exp);
      if (got >= 0) begin
        wb_ack = 1'b1;
        cyc(1);
        wb_ack = 1'b0;
        check("R6 clr_valid", int'(clr_valid), 1);
        check("R6 clr_idx", int'(clr_idx), got);
        check("R6 req dropped", int'(wb_req), 0);
        if (clr_valid) dirty_m[clr_idx] = 1'b0;
        cyc(1);
        check("R6 single pulse", int'(clr_valid), 0);
      end
    end

    // R4: pointer steps and wraps
    do_reset();
    dirty_m = '0;
    bus_idle = 1'b1;
    cyc(3);
    check("R4 step", int'(scan_idx), 3);
    cyc(17);
    check("R4 wrap", int'(scan_idx), 4);

    // R3: busy bus and pending demand both freeze scanning
    do_reset();
    dirty_m = 16'h0004;
    cyc(THR + 5);
    check("R3 busy hold", int'(scan_idx), 0);
    bus_idle = 1'b1; dem_pend = 1'b1;
    cyc(10);
    check("R3 demand hold", int'(scan_idx), 0);
    check("R3 no req", int'(wb_req), 0);
    dem_pend = 1'b0;
    wait_req(10, got);
    check("R3 issue after release", got, 2);

    // R5 / R7: held request, rewritten line keeps dirty bit
    begin
      int sidx;
      sidx = int'(scan_idx);
      for (int k = 0; k < 8; k++) begin
        bus_idle = k[0]; dem_pend = k[1];
        cyc(1);
        check("R5 req held", int'(wb_req), 1);
        check("R5 idx held", int'(wb_idx), 2);
        check("R5 scan frozen", int'(scan_idx), sidx);
      end
    end
    bus_idle = 1'b1; dem_pend = 1'b0;
    acc_valid = 1'b1; acc_idx = 4'd2; acc_write = 1'b1;
    cyc(1);
    acc_valid = 1'b0; acc_write = 1'b0;
    wb_ack = 1'b1;
    cyc(1);
    wb_ack = 1'b0;
    check("R7 no clear", int'(clr_valid), 0);
    check("R7 req done", int'(wb_req), 0);
    cyc(1);
    check("R7 no clear later", int'(clr_valid), 0);

    // R8: access to candidate before issue drops it
    do_reset();
    dirty_m = 16'h0001;
    cyc(THR + 5);
    bus_idle = 1'b1;
    cyc(1);
    check("R4 moved past candidate", int'(scan_idx), 1);
    acc_valid = 1'b1; acc_idx = 4'd0; acc_write = 1'b0; dem_pend = 1'b1;
    cyc(1);
    acc_valid = 1'b0; dem_pend = 1'b0;
    check("R8 not issued", int'(wb_req), 0);
    wait_req(20, got);
    check("R8 dropped", got, -1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule